// File: doc/BRIEF.md
# Reset-Gated Chip-Enable Passthrough

This block sits between a host and a battery-backed memory. It relays the host's active-low chip-enable to the memory while the supply is healthy. It blocks that chip-enable while the supply monitor reports a fault, so that a collapsing supply cannot cause a spurious write. The block does not cut off an access that has already started. If the gated chip-enable is already low when the fault flag rises, that access may finish. It is allowed a grace window of at most `GRACE_CYC` clock cycles, and it ends earlier if the host releases the chip-enable first.

The output is registered, so it lags the inputs by one clock. After the grace window closes, or after the host releases the chip-enable, the output stays high until the fault flag drops. The same holds when the chip-enable goes low only after the fault has been seen. When the fault flag drops, plain passthrough resumes. The analog comparator that produces the fault flag is outside this block, as is the battery switchover.

Top module: `cegate_top`

## Requirements
- R1: While `rst` is high, `ce_out_n` is driven high (inactive) from the next clock edge on.
- R2: With `fault` low, `ce_out_n` equals the value `ce_in_n` had at the previous clock edge. Every transition passes, one cycle late.
- R3: When `fault` is sampled high while `ce_out_n` is high, `ce_out_n` stays high for as long as `fault` remains high.
- R4: When `fault` is first sampled high while `ce_out_n` is low and `ce_in_n` is low, `ce_out_n` stays low (an in-flight access). It goes high on the edge that samples `ce_in_n` high.
- R5: An in-flight access held through a fault keeps `ce_out_n` low for at most `GRACE_CYC` cycles, counted from the edge that first samples `fault` high. On the next edge `ce_out_n` goes high even if `ce_in_n` is still low.
- R6: After the grace window ends by release or by expiry, any further low on `ce_in_n` is ignored and `ce_out_n` stays high until `fault` drops.
- R7: A low on `ce_in_n` that begins after `fault` is already high starts no grace window, and `ce_out_n` stays high.
- R8: On the first edge that samples `fault` low, passthrough resumes (`ce_out_n` takes that edge's `ce_in_n`).
- R9: If `fault` drops during a grace window, the window is abandoned without expiry. A later fault with an in-flight access starts a fresh window of full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_in_n | input | 1 | Host chip-enable, active low |
| fault | input | 1 | Supply-fault flag from the supply monitor, high while the supply is below threshold |
| ce_out_n | output | 1 | Gated chip-enable to memory, active low, registered |

## Verification
The bench builds the block with `GRACE_CYC` set to 6 instead of the default of 1875 (15 µs at 125 MHz). This makes the expiry edge reachable within a few cycles, so the last low cycle and the first forced-high cycle can both be checked exactly. The small window also lets one run cover both ways a window can end, plus a fault that drops mid-window and is followed by a fresh full-length window. A reset applied during a grace window is included to show that reset overrides the held access.

// File: rtl/cegate_pkg.sv
package cegate_pkg;
  typedef enum logic [1:0] {
    GS_PASS  = 2'd0,
    GS_GRACE = 2'd1,
    GS_HOLD  = 2'd2
  } gate_state_t;
endpackage

// File: rtl/cegate_timer.sv
module cegate_timer #(
  parameter int GRACE_CYC = 1875,
  localparam int CW = $clog2(GRACE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic adv,
  output logic expired
);
  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q == CW'(GRACE_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(1);
    end else if (adv && !expired) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/cegate_ctrl.sv
module cegate_ctrl
  import cegate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ce_in_n,
  input  logic fault,
  input  logic out_q,
  input  logic expired,
  output logic out_d,
  output logic tmr_start,
  output logic tmr_adv
);
  gate_state_t st_q, st_d;

  always_comb begin
    st_d      = st_q;
    out_d     = 1'b1;
    tmr_start = 1'b0;
    tmr_adv   = 1'b0;
    unique case (st_q)
      GS_PASS: begin
        if (!fault) begin
          out_d = ce_in_n;
        end else if (!out_q && !ce_in_n) begin
          // access already passed through: let it finish
          st_d      = GS_GRACE;
          out_d     = 1'b0;
          tmr_start = 1'b1;
        end else begin
          st_d = GS_HOLD;
        end
      end
      GS_GRACE: begin
        if (!fault) begin
          st_d  = GS_PASS;
          out_d = ce_in_n;
        end else if (ce_in_n || expired) begin
          st_d = GS_HOLD;
        end else begin
          out_d   = 1'b0;
          tmr_adv = 1'b1;
        end
      end
      GS_HOLD: begin
        if (!fault) begin
          st_d  = GS_PASS;
          out_d = ce_in_n;
        end
      end
      default: st_d = GS_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= GS_PASS;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/cegate_outreg.sv
module cegate_outreg (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b1;
    else     q <= d;
  end
endmodule

// File: rtl/cegate_top.sv
module cegate_top #(
  parameter int GRACE_CYC = 1875
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_in_n,
  input  logic fault,
  output logic ce_out_n
);
  logic out_d, tmr_start, tmr_adv, expired;

  cegate_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ce_in_n   (ce_in_n),
    .fault     (fault),
    .out_q     (ce_out_n),
    .expired   (expired),
    .out_d     (out_d),
    .tmr_start (tmr_start),
    .tmr_adv   (tmr_adv)
  );

  cegate_timer #(.GRACE_CYC(GRACE_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (tmr_start),
    .adv     (tmr_adv),
    .expired (expired)
  );

  cegate_outreg u_out (
    .clk (clk),
    .rst (rst),
    .d   (out_d),
    .q   (ce_out_n)
  );
endmodule

// File: rtl/cegate_chk.sv
module cegate_chk #(
  parameter int GRACE_CYC = 1875,
  localparam int RW = $clog2(GRACE_CYC + 2) + 1
) (
  input logic clk,
  input logic rst,
  input logic ce_in_n,
  input logic fault,
  input logic ce_out_n
);
  // run of sampled cycles with fault high and output low
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !(fault && !ce_out_n)) run_q <= '0;
    else if (run_q != '1)             run_q <= run_q + RW'(1);
  end

  // R1
  reset_high_chk: assert property (@(posedge clk) rst |=> ce_out_n);

  // R2
  passthrough_chk: assert property (@(posedge clk) disable iff (rst)
    !fault |=> (ce_out_n == $past(ce_in_n)));

  // R3
  stay_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (fault && ce_out_n) |=> ce_out_n);

  // R4
  release_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (fault && !ce_out_n && ce_in_n) |=> ce_out_n);

  // R5: the first sampled cycle is the passthrough low, then GRACE_CYC held cycles
  grace_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= RW'(GRACE_CYC + 1));
endmodule

bind cegate_top cegate_chk #(.GRACE_CYC(GRACE_CYC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ce_in_n  (ce_in_n),
  .fault    (fault),
  .ce_out_n (ce_out_n)
);

// File: tb/sim_cegate_top.sv
module sim_cegate_top;
  localparam int G = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_in_n = 1'b1;
  logic fault = 1'b0;
  logic ce_out_n;
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;

  always #4 clk = ~clk;

  cegate_top #(.GRACE_CYC(G)) u0 (
    .clk      (clk),
    .rst      (rst),
    .ce_in_n  (ce_in_n),
    .fault    (fault),
    .ce_out_n (ce_out_n)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // drive at negedge, one posedge, check at next negedge
  task automatic step(input logic c, input logic f);
    ce_in_n = c;
    fault   = f;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp);
    n_chk++;
    if (ce_out_n !== exp) begin
      n_bad++;
      $display("FAIL %s: ce_out_n=%b expected %b", req, ce_out_n, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R1 reset", 1'b1);
    rst = 1'b0;
  endtask

  task automatic t_pass();
    logic [7:0] pat = 8'b0110_0101;
    for (int i = 0; i < 8; i++) begin
      step(pat[i], 1'b0);
      chk("R2 passthrough", pat[i]);
    end
  endtask

  task automatic t_idle_fault();
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    chk("R3 idle fault", 1'b1);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b1);
      chk("R7 late low ignored", 1'b1);
    end
    step(1'b0, 1'b0);
    chk("R8 resume", 1'b0);
  endtask

  task automatic t_release();
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    chk("R4 in-flight held", 1'b0);
    step(1'b0, 1'b1);
    chk("R4 in-flight held", 1'b0);
    step(1'b1, 1'b1);
    chk("R4 release ends window", 1'b1);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1);
      chk("R6 low after release ignored", 1'b1);
    end
    step(1'b1, 1'b0);
    chk("R8 resume high", 1'b1);
  endtask

  task automatic t_expire();
    step(1'b0, 1'b0);
    for (int k = 1; k <= G; k++) begin
      step(1'b0, 1'b1);
      chk("R5 low within window", 1'b0);
    end
    step(1'b0, 1'b1);
    chk("R5 expiry forces high", 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    chk("R6 low after expiry ignored", 1'b1);
    step(1'b0, 1'b0);
    chk("R8 resume after expiry", 1'b0);
  endtask

  task automatic t_drop_mid();
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    for (int i = 0; i < G + 2; i++) begin
      step(1'b0, 1'b0);
      chk("R9 drop abandons window", 1'b0);
    end
    for (int k = 1; k <= G; k++) begin
      step(1'b0, 1'b1);
      chk("R9 fresh full window", 1'b0);
    end
    step(1'b0, 1'b1);
    chk("R9 fresh window expires", 1'b1);
    step(1'b1, 1'b0);
  endtask

  task automatic t_reset_in_grace();
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    chk("R4 held before reset", 1'b0);
    rst = 1'b1;
    step(1'b0, 1'b1);
    chk("R1 reset overrides window", 1'b1);
    rst = 1'b0;
    step(1'b1, 1'b0);
    chk("R2 after reset", 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_pass();
    t_idle_fault();
    t_release();
    t_expire();
    t_drop_mid();
    t_reset_in_grace();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule